// File: doc/BRIEF.md
# Indirect Branch Landing Checker

This block observes retired control-flow events from a simple pipeline model and enforces a landing rule for indirect transfers. When an indirect call or an indirect jump retires while enforcement is on, the checker records the branch target and waits for the first fetch at that target. It then compares the first four fetched bytes with a fixed end-branch marker. If they differ, it raises a control-protection fault. The fault is a one-cycle pulse, and it comes with the address of the offending target.

Direct calls, direct jumps, conditional branches and returns never start a check. Returns belong to a separate return-address unit. When enforcement is off, nothing is armed and the marker is an ordinary no-op. The controller is a two-state machine. The state IDLE means no check is pending. The state WAIT_TARGET means a target has been captured and its fetch is expected. There are four transitions. ARM goes from IDLE to WAIT_TARGET on an indirect strobe. STALL keeps WAIT_TARGET while fetch-valid is low. RETARGET keeps WAIT_TARGET when a new strobe arrives, either with no fetch or together with the fetch that resolves the previous target. RESOLVE goes from WAIT_TARGET to IDLE on a valid fetch with no new strobe.

Top module: `ibr_land_chk`

## Requirements
- R1: A synchronous reset puts the block in IDLE (`armed`=0), with `fault_pulse`=0 and `fault_addr`=0.
- R2: A strobe with `br_valid`=1, `enf_en`=1 and `br_kind` equal to 4 (indirect call via register), 5 (indirect jump via register) or 6 (indirect jump via memory operand) sets `armed` to 1 in the next cycle.
- R3: The kinds 0 (direct jump), 1 (direct call), 2 (conditional branch), 3 (return) and 7 (reserved) never set `armed`.
- R4: While `armed`=1 and `fetch_valid`=0, the block stays armed and raises no fault, for any number of stall cycles.
- R5: A valid fetch with `fetch_bytes` equal to the marker F3 0F 1E FA clears `armed` in the next cycle and raises no fault. The lowest-address byte F3 sits at bits [7:0], so the word reads 32'hFA1E0FF3.
- R6: A valid fetch while armed whose bytes differ from the marker in any bit raises `fault_pulse` in the next cycle, with `fault_addr` equal to the captured target. This includes bytes that form other valid instructions.
- R7: Each violating fetch produces exactly one cycle of `fault_pulse`.
- R8: With `enf_en`=0, no strobe arms the block. A fetch taken while `enf_en`=0 clears a pending check without a fault.
- R9: `fetch_valid` while IDLE has no effect: no fault, and the block stays unarmed.
- R10: When a valid fetch and a new indirect strobe arrive in the same cycle, the fetch is judged against the old target and the new target is armed.
- R11: `fault_addr` changes only in a cycle where `fault_pulse` is 1, and it holds its value between faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enf_en | input | 1 | Enforcement enable |
| br_valid | input | 1 | Retired control-flow event strobe |
| br_kind | input | 3 | Branch type code (see R2, R3) |
| br_target | input | ADDR_W | Target address of the retired branch |
| fetch_valid | input | 1 | Target fetch bytes are valid this cycle |
| fetch_bytes | input | 8*MARK_BYTES | First fetched bytes, lowest address in bits [7:0] |
| fault_pulse | output | 1 | One-cycle control-protection fault |
| fault_addr | output | ADDR_W | Target address of the last fault |
| armed | output | 1 | High while a target check is pending (WAIT_TARGET) |

## Verification
The hardest case to reach from the ports is a single cycle that carries two events: the fetch that resolves the old target and the strobe that arms a new one. Getting it wrong can drop a fault or report the wrong address. The bench drives this case directly, once with a bad fetch and once with a good one, and then resolves the new target. It also sweeps every single-bit corruption of the marker, with stall lengths that cycle through 0 to 3, so that each byte lane's comparison is checked through a stalled WAIT_TARGET.

// File: rtl/ibr_land_pkg.sv
package ibr_land_pkg;

    typedef enum logic [2:0] {
        BK_DIR_JMP  = 3'd0,
        BK_DIR_CALL = 3'd1,
        BK_COND     = 3'd2,
        BK_RET      = 3'd3,
        BK_IND_CREG = 3'd4,
        BK_IND_JREG = 3'd5,
        BK_IND_JMEM = 3'd6,
        BK_RSVD     = 3'd7
    } br_kind_e;

    typedef enum logic {
        ST_IDLE        = 1'b0,
        ST_WAIT_TARGET = 1'b1
    } land_state_e;

    localparam int unsigned MARK_BYTES_DEF = 4;
    localparam logic [31:0] MARK_WORD_DEF  = 32'hFA1E0FF3;

endpackage

// File: rtl/ibr_kind_decode.sv
module ibr_kind_decode
    import ibr_land_pkg::*;
(
    input  logic       br_valid,
    input  logic [2:0] br_kind,
    input  logic       enf_en,
    output logic       arm_req
);
    logic is_indirect;

    always_comb begin
        unique case (br_kind_e'(br_kind))
            BK_IND_CREG, BK_IND_JREG, BK_IND_JMEM: is_indirect = 1'b1;
            default:                               is_indirect = 1'b0;
        endcase
        arm_req = br_valid && enf_en && is_indirect;
    end

endmodule

// File: rtl/ibr_marker_match.sv
module ibr_marker_match #(
    parameter int unsigned        MARK_BYTES = 4,
    parameter logic [8*MARK_BYTES-1:0] MARK_WORD = 32'hFA1E0FF3
) (
    input  logic [8*MARK_BYTES-1:0] bytes_in,
    output logic                    is_marker
);
    logic [MARK_BYTES-1:0] lane_eq;

    for (genvar b = 0; b < MARK_BYTES; b++) begin : g_lane
        assign lane_eq[b] = (bytes_in[8*b +: 8] == MARK_WORD[8*b +: 8]);
    end

    assign is_marker = &lane_eq;

endmodule

// File: rtl/ibr_land_fsm.sv
module ibr_land_fsm
    import ibr_land_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enf_en,
    input  logic              arm_req,
    input  logic [ADDR_W-1:0] br_target,
    input  logic              fetch_valid,
    input  logic              is_marker,
    output logic              fault_pulse,
    output logic [ADDR_W-1:0] fault_addr,
    output logic              armed
);
    land_state_e       state_q, state_d;
    logic [ADDR_W-1:0] tgt_q, tgt_d;
    logic              violate;

    always_comb begin
        state_d = state_q;
        tgt_d   = tgt_q;
        violate = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (arm_req) begin
                    state_d = ST_WAIT_TARGET;
                    tgt_d   = br_target;
                end
            end
            ST_WAIT_TARGET: begin
                if (fetch_valid) begin
                    violate = enf_en && !is_marker;
                    state_d = arm_req ? ST_WAIT_TARGET : ST_IDLE;
                end
                if (arm_req) begin
                    tgt_d = br_target;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tgt_q   <= '0;
        end else begin
            state_q <= state_d;
            tgt_q   <= tgt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_pulse <= 1'b0;
            fault_addr  <= '0;
        end else begin
            fault_pulse <= violate;
            if (violate) begin
                fault_addr <= tgt_q;
            end
        end
    end

    assign armed = (state_q == ST_WAIT_TARGET);

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (armed && !fetch_valid) |=> (armed && !fault_pulse));

    p_resolve_r5: assert property (@(posedge clk) disable iff (rst)
        (armed && fetch_valid && is_marker && !arm_req) |=> (!armed && !fault_pulse));

    p_cause_r6: assert property (@(posedge clk) disable iff (rst)
        fault_pulse |-> $past(armed && fetch_valid && enf_en));

    p_addr_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !$stable(fault_addr) |-> fault_pulse);

endmodule

// File: rtl/ibr_land_chk.sv
module ibr_land_chk
    import ibr_land_pkg::*;
#(
    parameter int unsigned             ADDR_W     = 32,
    parameter int unsigned             MARK_BYTES = MARK_BYTES_DEF,
    parameter logic [8*MARK_BYTES-1:0] MARK_WORD  = MARK_WORD_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    enf_en,
    input  logic                    br_valid,
    input  logic [2:0]              br_kind,
    input  logic [ADDR_W-1:0]       br_target,
    input  logic                    fetch_valid,
    input  logic [8*MARK_BYTES-1:0] fetch_bytes,
    output logic                    fault_pulse,
    output logic [ADDR_W-1:0]       fault_addr,
    output logic                    armed
);
    logic arm_req;
    logic is_marker;

    ibr_kind_decode u_dec (
        .br_valid (br_valid),
        .br_kind  (br_kind),
        .enf_en   (enf_en),
        .arm_req  (arm_req)
    );

    ibr_marker_match #(
        .MARK_BYTES (MARK_BYTES),
        .MARK_WORD  (MARK_WORD)
    ) u_match (
        .bytes_in  (fetch_bytes),
        .is_marker (is_marker)
    );

    ibr_land_fsm #(
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .enf_en      (enf_en),
        .arm_req     (arm_req),
        .br_target   (br_target),
        .fetch_valid (fetch_valid),
        .is_marker   (is_marker),
        .fault_pulse (fault_pulse),
        .fault_addr  (fault_addr),
        .armed       (armed)
    );

    p_arm_r2: assert property (@(posedge clk) disable iff (rst)
        (br_valid && enf_en && (br_kind inside {3'd4, 3'd5, 3'd6})) |=> armed);

    p_noarm_r3: assert property (@(posedge clk) disable iff (rst)
        (!armed && !(br_valid && enf_en && (br_kind inside {3'd4, 3'd5, 3'd6}))) |=> !armed);

    p_enf_off_r8: assert property (@(posedge clk) disable iff (rst)
        !enf_en |=> !fault_pulse);

    p_idle_fetch_r9: assert property (@(posedge clk) disable iff (rst)
        !armed |=> !fault_pulse);

endmodule

// File: tb/ibr_land_chk_tb.sv
module ibr_land_chk_tb;
    localparam logic [31:0] MARK = 32'hFA1E0FF3;

    logic        clk = 1'b0;
    logic        rst;
    logic        enf_en;
    logic        br_valid;
    logic [2:0]  br_kind;
    logic [31:0] br_target;
    logic        fetch_valid;
    logic [31:0] fetch_bytes;
    logic        fault_pulse;
    logic [31:0] fault_addr;
    logic        armed;

    int n_vec  = 0;
    int n_fail = 0;
    int n_cyc  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ibr_land_chk u_dut (
        .clk         (clk),
        .rst         (rst),
        .enf_en      (enf_en),
        .br_valid    (br_valid),
        .br_kind     (br_kind),
        .br_target   (br_target),
        .fetch_valid (fetch_valid),
        .fetch_bytes (fetch_bytes),
        .fault_pulse (fault_pulse),
        .fault_addr  (fault_addr),
        .armed       (armed)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic cyc(input logic bv, input logic [2:0] k, input logic [31:0] t,
                       input logic fv, input logic [31:0] fb, input logic en);
        br_valid    = bv;
        br_kind     = k;
        br_target   = t;
        fetch_valid = fv;
        fetch_bytes = fb;
        enf_en      = en;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_cyc();
        cyc(1'b0, 3'd0, 32'h0, 1'b0, 32'h0, 1'b1);
    endtask

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 100000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected completion", n_cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        br_valid = 0; br_kind = 0; br_target = 0;
        fetch_valid = 0; fetch_bytes = 0; enf_en = 1;
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        chk("R1 armed", armed, 0);
        chk("R1 fault", fault_pulse, 0);
        chk("R1 addr", fault_addr, 0);
        rst = 1'b0;

        // R2 / R3 / R8 / R9: every kind with enforcement on and off
        for (int en = 0; en < 2; en++) begin
            for (int k = 0; k < 8; k++) begin
                automatic logic exp_arm = (en == 1) && (k >= 4) && (k <= 6);
                cyc(1'b1, 3'(k), 32'(k * 16 + en), 1'b0, 32'h0, 1'(en));
                chk(exp_arm ? "R2 arm" : "R3/R8 no arm", armed, exp_arm);
                // resolving fetch; when idle this is R9 (bad bytes ignored)
                cyc(1'b0, 3'd0, 32'h0, 1'b1, exp_arm ? MARK : 32'hE5894855, 1'(en));
                chk(exp_arm ? "R5 no fault" : "R9 no fault", fault_pulse, 0);
                chk(exp_arm ? "R5 disarm" : "R9 stay idle", armed, 0);
            end
        end

        // R4 / R6 / R7 / R11: every single-bit corruption of the marker
        for (int by = 0; by < 4; by++) begin
            for (int bi = 0; bi < 8; bi++) begin
                automatic logic [31:0] tgt = 32'h1000_0000 + 32'(by * 8 + bi);
                cyc(1'b1, 3'(4 + (bi % 3)), tgt, 1'b0, 32'h0, 1'b1);
                chk("R2 arm sweep", armed, 1);
                for (int s = 0; s < (bi % 4); s++) begin
                    cyc(1'b0, 3'd0, 32'h0, 1'b0, MARK ^ 32'hFFFF, 1'b1);
                    chk("R4 stall armed", armed, 1);
                    chk("R4 stall no fault", fault_pulse, 0);
                end
                cyc(1'b0, 3'd0, 32'h0, 1'b1, MARK ^ (32'h1 << (by * 8 + bi)), 1'b1);
                chk("R6 fault", fault_pulse, 1);
                chk("R6 addr", fault_addr, tgt);
                chk("R6 disarm", armed, 0);
                idle_cyc();
                chk("R7 single pulse", fault_pulse, 0);
                chk("R11 addr hold", fault_addr, tgt);
            end
        end

        // R6: valid but different instruction bytes at the target
        cyc(1'b1, 3'd5, 32'hCAFE_0040, 1'b0, 32'h0, 1'b1);
        cyc(1'b0, 3'd0, 32'h0, 1'b1, 32'hE5894855, 1'b1);
        chk("R6 other insn fault", fault_pulse, 1);
        chk("R6 other insn addr", fault_addr, 32'hCAFE_0040);
        idle_cyc();

        // R8: enforcement dropped before the fetch
        cyc(1'b1, 3'd6, 32'hBEEF_0000, 1'b0, 32'h0, 1'b1);
        cyc(1'b0, 3'd0, 32'h0, 1'b1, 32'h0, 1'b0);
        chk("R8 no fault", fault_pulse, 0);
        chk("R8 disarm", armed, 0);
        chk("R11 addr kept", fault_addr, 32'hCAFE_0040);

        // R10: fetch of the old target together with a new strobe
        cyc(1'b1, 3'd4, 32'hA000_0000, 1'b0, 32'h0, 1'b1);
        cyc(1'b1, 3'd5, 32'hB000_0000, 1'b1, 32'h0, 1'b1);
        chk("R10 old fault", fault_pulse, 1);
        chk("R10 old addr", fault_addr, 32'hA000_0000);
        chk("R10 rearmed", armed, 1);
        cyc(1'b1, 3'd6, 32'hC000_0000, 1'b1, 32'h1234_5678, 1'b1);
        chk("R10 second fault", fault_pulse, 1);
        chk("R10 second addr", fault_addr, 32'hB000_0000);
        chk("R10 rearmed again", armed, 1);
        cyc(1'b0, 3'd0, 32'h0, 1'b1, MARK, 1'b1);
        chk("R10 good resolve", fault_pulse, 0);
        chk("R10 disarm", armed, 0);
        chk("R10 addr hold", fault_addr, 32'hB000_0000);

        // R10: good fetch with new strobe, then bad fetch of the new one
        cyc(1'b1, 3'd4, 32'hD000_0000, 1'b0, 32'h0, 1'b1);
        cyc(1'b1, 3'd4, 32'hE000_0000, 1'b1, MARK, 1'b1);
        chk("R10 good old", fault_pulse, 0);
        chk("R10 armed new", armed, 1);
        cyc(1'b0, 3'd0, 32'h0, 1'b1, 32'h0, 1'b1);
        chk("R10 new fault", fault_pulse, 1);
        chk("R10 new addr", fault_addr, 32'hE000_0000);

        // R1: reset clears a pending check
        cyc(1'b1, 3'd5, 32'h5555_0000, 1'b0, 32'h0, 1'b1);
        rst = 1'b1;
        idle_cyc();
        rst = 1'b0;
        chk("R1 rearm reset armed", armed, 0);
        chk("R1 rearm reset addr", fault_addr, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule